// File: doc/BRIEF.md
# Transport Stream PID Gate

This block passes or suppresses whole MPEG transport-stream packets on a number of independent byte streams. Two streams is the default. Each stream has its own drop bitmap with one bit for every 13-bit packet identifier (PID). The bitmap is organised as bytes: PID bits 12:3 select the byte and PID bits 2:0 select the bit inside it. A bit at 1 suppresses packets carrying that PID, and a bit at 0 lets them through. The first four bytes of every bitmap cover PIDs 0x00 to 0x1F. They are held at zero, so those PIDs can never be blocked.

Software reaches the bitmaps through three byte registers. Two registers form a pointer, holding the byte address and the stream number. The third is a data register that reads and writes the byte under the pointer. Bit changes are made by software as read-modify-write. The bitmap storage has two ports, so host accesses never hold up the stream lookups.

On the stream side, a packet begins at a start strobe whose byte is the sync value 0x47. The PID is read from header bytes 1 and 2, and the looked-up bit decides the fate of the whole packet. Every stream output follows its input by a fixed four cycles.

Top module: `tsf_pid_filter`

## Requirements
- R1: The pointer low register (host_sel 0) holds byte address bits 7:0, which are PID bits 10:3. The pointer high register (host_sel 1) holds byte address bits 9:8 (PID bits 12:11) in its bits 1:0, and the stream number in its bit 2. Data accesses (host_sel 2) reach byte {high[1:0], low} of the selected stream. host_sel 3 has no effect.
- R2: host_rdata shows the byte under the pointer. It reflects any pointer or data write within two clock cycles of that write.
- R3: Within a byte, bit PID[2:0] controls that PID: 1 drops its packets and 0 forwards them. A write to one stream's bitmap never changes another stream's bitmap.
- R4: Bytes 0 to 3 of every bitmap always read 0x00, and data writes to them have no effect. Packets with PID 0x00 to 0x1F are therefore always forwarded.
- R5: Reset starts a fill that lasts 1024 cycles. Throughout it, and afterwards, bytes 4 to 1023 read 0xFF until they are written. Data writes made during the fill are ignored, and so are any PIDs from 0x20 upward.
- R6: A packet starts on an in_start beat whose byte is 0x47. Its PID is {byte1[4:0], byte2}. Header bytes 0 to 2 must arrive on back-to-back cycles, and a packet is at least 3 bytes long.
- R7: A forwarded byte appears on the outputs exactly 4 cycles after it was presented, with its data and start flag unchanged. Gaps in the input are kept.
- R8: All bytes of a packet share one decision. A packet ends after 188 bytes or at the next start. Bytes beyond the 188th, and bytes after a start whose byte is not 0x47, are never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Register select: 0 pointer low, 1 pointer high, 2 data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Bitmap byte under the pointer |
| in_valid | input | NUM_CH | Per-stream byte valid |
| in_start | input | NUM_CH | Per-stream packet start strobe |
| in_data | input | 8*NUM_CH | Per-stream byte, stream c in bits 8c+7:8c |
| out_valid | output | NUM_CH | Per-stream forwarded byte valid |
| out_start | output | NUM_CH | Per-stream forwarded packet start |
| out_data | output | 8*NUM_CH | Per-stream forwarded byte |

## Verification
The bench builds the block with its defaults: two streams, 13-bit PIDs, 1024-byte bitmaps, 188-byte packets and four always-open bytes. With two streams, the channel bit of the pointer and the separation between bitmaps can be tested, because the same PID gets different programming on each stream. A 1024-byte bitmap gives a fill that is short enough to probe both during and after it, and it makes the top and bottom byte addresses reachable. The 188-byte length lets overlong and truncated packets exercise the packet-boundary rule.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
   localparam int BYTE_W     = 8;
   localparam int BIT_IDX_W  = 3;
   localparam int LOOKUP_LAT = 4;
   localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h47;

   typedef enum logic [1:0] {
      SEL_PTR_LO = 2'd0,
      SEL_PTR_HI = 2'd1,
      SEL_DATA   = 2'd2,
      SEL_RSVD   = 2'd3
   } host_sel_e;

   typedef struct packed {
      logic              start;
      logic              in_pkt;
      logic [BYTE_W-1:0] data;
   } beat_t;
endpackage

// File: rtl/tsf_host_regs.sv
module tsf_host_regs
   import tsf_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int CH_W   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        sel,
   input  logic [BYTE_W-1:0] wdata,
   output logic [ADDR_W-1:0] ptr_addr,
   output logic [CH_W-1:0]   ptr_ch,
   output logic              data_we
);
   localparam int HI_ADDR_W = ADDR_W - BYTE_W;

   logic [BYTE_W-1:0]    lo_q;
   logic [HI_ADDR_W-1:0] hi_addr_q;
   logic [CH_W-1:0]      ch_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q      <= '0;
         hi_addr_q <= '0;
         ch_q      <= '0;
      end else if (we) begin
         case (host_sel_e'(sel))
            SEL_PTR_LO: lo_q <= wdata;
            SEL_PTR_HI: begin
               hi_addr_q <= wdata[HI_ADDR_W-1:0];
               ch_q      <= wdata[HI_ADDR_W +: CH_W];
            end
            default: ;
         endcase
      end
   end

   assign ptr_addr = {hi_addr_q, lo_q};
   assign ptr_ch   = ch_q;
   assign data_we  = we && (host_sel_e'(sel) == SEL_DATA);
endmodule

// File: rtl/tsf_bitmap_ram.sv
module tsf_bitmap_ram
   import tsf_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int OPEN_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [BYTE_W-1:0] a_wdata,
   output logic [BYTE_W-1:0] a_rdata,
   input  logic [ADDR_W-1:0] b_addr,
   output logic [BYTE_W-1:0] b_rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] OPEN_LIM = ADDR_W'(OPEN_BYTES);

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [ADDR_W:0]   fill_cnt;
   logic              filling;

   function automatic logic [BYTE_W-1:0] fill_val(input logic [ADDR_W-1:0] a);
      return (a < OPEN_LIM) ? '0 : '1;
   endfunction

   assign filling = !fill_cnt[ADDR_W];

   always_ff @(posedge clk) begin
      if (!rst_n)       fill_cnt <= '0;
      else if (filling) fill_cnt <= fill_cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (filling)
         mem[fill_cnt[ADDR_W-1:0]] <= fill_val(fill_cnt[ADDR_W-1:0]);
      else if (a_we && a_addr >= OPEN_LIM)
         mem[a_addr] <= a_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_rdata <= '0;
         b_rdata <= '0;
      end else begin
         a_rdata <= filling ? fill_val(a_addr) : mem[a_addr];
         b_rdata <= filling ? fill_val(b_addr) : mem[b_addr];
      end
   end
endmodule

// File: rtl/tsf_pid_gate.sv
module tsf_pid_gate
   import tsf_pkg::*;
#(
   parameter int PID_W   = 13,
   parameter int PKT_LEN = 188
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_start,
   input  logic [BYTE_W-1:0]        in_data,
   output logic [PID_W-BIT_IDX_W-1:0] lk_addr,
   input  logic [BYTE_W-1:0]        lk_rdata,
   output logic                     out_valid,
   output logic                     out_start,
   output logic [BYTE_W-1:0]        out_data
);
   localparam int CNT_W  = $clog2(PKT_LEN + 1);
   localparam int HDR1_W = PID_W - BYTE_W;
   localparam logic [CNT_W-1:0] LEN_C = CNT_W'(PKT_LEN);

   logic                 active;
   logic [CNT_W-1:0]     cnt;
   logic [CNT_W-1:0]     idx;
   logic [HDR1_W-1:0]    hdr1;
   logic                 beat_pkt, lk_fire, lk_pend, keep;
   logic [PID_W-1:0]     pid;
   logic [BIT_IDX_W-1:0] bitsel_q;
   beat_t                dly [LOOKUP_LAT];

   assign idx      = in_start ? '0 : cnt;
   assign beat_pkt = in_valid && (in_start ? (in_data == SYNC_BYTE)
                                           : (active && cnt < LEN_C));
   assign pid      = {hdr1, in_data};
   assign lk_addr  = pid[PID_W-1:BIT_IDX_W];
   assign lk_fire  = beat_pkt && (idx == CNT_W'(2));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cnt      <= '0;
         hdr1     <= '0;
         lk_pend  <= 1'b0;
         bitsel_q <= '0;
         keep     <= 1'b0;
      end else begin
         if (in_valid) begin
            if (in_start) begin
               active <= (in_data == SYNC_BYTE);
               cnt    <= CNT_W'(1);
            end else if (active) begin
               if (cnt == LEN_C) active <= 1'b0;
               else              cnt    <= cnt + 1'b1;
            end
         end
         if (beat_pkt && idx == CNT_W'(1)) hdr1 <= in_data[HDR1_W-1:0];
         lk_pend  <= lk_fire;
         bitsel_q <= pid[BIT_IDX_W-1:0];
         if (lk_pend) keep <= ~lk_rdata[bitsel_q];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LOOKUP_LAT; i++) dly[i] <= '0;
      end else begin
         dly[0] <= '{start: in_start, in_pkt: beat_pkt, data: in_data};
         for (int i = 1; i < LOOKUP_LAT; i++) dly[i] <= dly[i-1];
      end
   end

   assign out_valid = dly[LOOKUP_LAT-1].in_pkt && keep;
   assign out_start = out_valid && dly[LOOKUP_LAT-1].start;
   assign out_data  = out_valid ? dly[LOOKUP_LAT-1].data : '0;
endmodule

// File: rtl/tsf_pid_filter.sv
module tsf_pid_filter
   import tsf_pkg::*;
#(
   parameter int NUM_CH     = 2,
   parameter int PID_W      = 13,
   parameter int PKT_LEN    = 188,
   parameter int OPEN_BYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     host_we,
   input  logic [1:0]               host_sel,
   input  logic [BYTE_W-1:0]        host_wdata,
   output logic [BYTE_W-1:0]        host_rdata,
   input  logic [NUM_CH-1:0]        in_valid,
   input  logic [NUM_CH-1:0]        in_start,
   input  logic [NUM_CH*BYTE_W-1:0] in_data,
   output logic [NUM_CH-1:0]        out_valid,
   output logic [NUM_CH-1:0]        out_start,
   output logic [NUM_CH*BYTE_W-1:0] out_data
);
   localparam int ADDR_W = PID_W - BIT_IDX_W;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (ADDR_W <= BYTE_W || (ADDR_W - BYTE_W + CH_W) > BYTE_W) begin : g_bad_pid_w
      $error("PID_W and NUM_CH do not fit the byte-wide pointer registers");
   end
   if (PKT_LEN < 4) begin : g_bad_len
      $error("PKT_LEN must cover the header");
   end
   if (OPEN_BYTES >= DEPTH) begin : g_bad_open
      $error("OPEN_BYTES must be below the bitmap depth");
   end

   logic [ADDR_W-1:0] ptr_addr;
   logic [CH_W-1:0]   ptr_ch;
   logic              data_we;
   logic [BYTE_W-1:0] host_byte [NUM_CH];

   tsf_host_regs #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(host_we), .sel(host_sel), .wdata(host_wdata),
      .ptr_addr(ptr_addr), .ptr_ch(ptr_ch), .data_we(data_we)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [ADDR_W-1:0] lk_addr;
      logic [BYTE_W-1:0] lk_rdata;

      tsf_bitmap_ram #(.ADDR_W(ADDR_W), .OPEN_BYTES(OPEN_BYTES)) u_ram (
         .clk(clk), .rst_n(rst_n),
         .a_we(data_we && ptr_ch == CH_W'(c)), .a_addr(ptr_addr),
         .a_wdata(host_wdata), .a_rdata(host_byte[c]),
         .b_addr(lk_addr), .b_rdata(lk_rdata)
      );

      tsf_pid_gate #(.PID_W(PID_W), .PKT_LEN(PKT_LEN)) u_gate (
         .clk(clk), .rst_n(rst_n),
         .in_valid(in_valid[c]), .in_start(in_start[c]),
         .in_data(in_data[c*BYTE_W +: BYTE_W]),
         .lk_addr(lk_addr), .lk_rdata(lk_rdata),
         .out_valid(out_valid[c]), .out_start(out_start[c]),
         .out_data(out_data[c*BYTE_W +: BYTE_W])
      );
   end

   always_comb begin
      host_rdata = '0;
      for (int c = 0; c < NUM_CH; c++)
         if (ptr_ch == CH_W'(c)) host_rdata = host_byte[c];
   end
endmodule

// File: rtl/tsf_pid_filter_chk.sv
module tsf_pid_filter_chk #(
   parameter int NUM_CH     = 2,
   parameter int ADDR_W     = 10,
   parameter int CH_W       = 1,
   parameter int OPEN_BYTES = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_CH-1:0]   in_valid,
   input logic [NUM_CH*8-1:0] in_data,
   input logic [NUM_CH-1:0]   out_valid,
   input logic [NUM_CH-1:0]   out_start,
   input logic [NUM_CH*8-1:0] out_data,
   input logic [7:0]          host_rdata,
   input logic [ADDR_W-1:0]   ptr_addr,
   input logic [CH_W-1:0]     ptr_ch
);
   localparam logic [ADDR_W-1:0] OPEN_LIM = ADDR_W'(OPEN_BYTES);

   AST_OPEN_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ptr_addr) < OPEN_LIM && $past(ptr_ch) == ptr_ch) |-> host_rdata == 8'h00); // R4

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[c] |-> $past(in_valid[c], 4)); // R7
      AST_DATA_INTACT: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[c] |-> out_data[c*8 +: 8] == $past(in_data[c*8 +: 8], 4)); // R7
      AST_START_IS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[c] && out_start[c]) |-> out_data[c*8 +: 8] == 8'h47); // R6
   end
endmodule

bind tsf_pid_filter tsf_pid_filter_chk #(
   .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W), .OPEN_BYTES(OPEN_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
   .out_valid(out_valid), .out_start(out_start), .out_data(out_data),
   .host_rdata(host_rdata), .ptr_addr(ptr_addr), .ptr_ch(ptr_ch)
);

// File: tb/tsf_pid_filter_tb.sv
module tsf_pid_filter_tb;
   localparam int NUM_CH  = 2;
   localparam int DEPTH   = 1024;
   localparam int PKT_LEN = 188;
   localparam int LAT     = 4;

   typedef struct packed { logic st; logic nogap; logic [7:0] d; } qb_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_we = 1'b0;
   logic [1:0] host_sel = 2'd3;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic [NUM_CH-1:0] in_valid = '0, in_start = '0, out_valid, out_start;
   logic [NUM_CH*8-1:0] in_data = '0, out_data;

   int n_vec = 0, n_bad = 0;
   logic [7:0] model [NUM_CH][DEPTH];
   qb_t q [NUM_CH][$];
   bit  pass_of [NUM_CH][4096];
   bit  m_act [NUM_CH];
   int  m_cnt [NUM_CH];
   int  m_ser [NUM_CH];
   logic [7:0] m_hdr1 [NUM_CH];
   bit  h_pkt [NUM_CH][8];
   int  h_ser [NUM_CH][8];
   logic [7:0] h_d [NUM_CH][8];
   bit  h_st [NUM_CH][8];
   int  wr_list[$];

   always #2 clk = ~clk;

   tsf_pid_filter u_dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .in_valid(in_valid), .in_start(in_start), .in_data(in_data),
      .out_valid(out_valid), .out_start(out_start), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic hwr(input logic [1:0] sel, input logic [7:0] val);
      @(negedge clk);
      host_we = 1'b1; host_sel = sel; host_wdata = val;
      @(negedge clk);
      host_we = 1'b0; host_sel = 2'd3;
   endtask

   task automatic set_ptr(input int c, input int a);
      hwr(2'd0, 8'(a));
      hwr(2'd1, {5'b0, 1'(c), 2'(a >> 8)});
   endtask

   task automatic tbl_write(input int c, input int a, input logic [7:0] v, input bit filling);
      set_ptr(c, a);
      hwr(2'd2, v);
      if (!filling && a >= 4) model[c][a] = v;
   endtask

   task automatic rd_chk(input int c, input int a, input string req);
      set_ptr(c, a);
      repeat (2) @(negedge clk);
      chk(host_rdata == model[c][a], req, host_rdata, model[c][a]);
   endtask

   function automatic bit pid_pass(input int c, input int pid);
      return !model[c][pid >> 3][pid & 7];
   endfunction

   // kind: 0 normal, 1 bad sync, 2 overlong, 3 short (40 bytes)
   task automatic gen_pkt(input int c, input int pid, input int kind);
      int n;
      n = (kind == 3) ? 40 : PKT_LEN;
      for (int i = 0; i < n; i++) begin
         qb_t b;
         b.st = (i == 0);
         b.nogap = (i == 1 || i == 2);
         if (i == 0)      b.d = (kind == 1) ? 8'h12 : 8'h47;
         else if (i == 1) b.d = {3'($urandom), 5'(pid >> 8)};
         else if (i == 2) b.d = 8'(pid);
         else             b.d = 8'($urandom);
         q[c].push_back(b);
      end
      if (kind == 2)
         for (int i = 0; i < 5; i++) q[c].push_back('{st: 1'b0, nogap: 1'b0, d: 8'($urandom)});
   endtask

   function automatic void model_beat(input int c, input int slot, input logic st, input logic [7:0] d);
      bit inp; int idx; int pid;
      if (st) begin inp = (d == 8'h47); idx = 0; end
      else begin inp = m_act[c] && m_cnt[c] < PKT_LEN; idx = m_cnt[c]; end
      if (inp && idx == 0) m_ser[c] = (m_ser[c] + 1) % 4096;
      if (inp && idx == 1) m_hdr1[c] = d;
      if (inp && idx == 2) begin
         pid = {m_hdr1[c][4:0], d};
         pass_of[c][m_ser[c]] = pid_pass(c, pid);
      end
      if (st) begin m_act[c] = (d == 8'h47); m_cnt[c] = 1; end
      else if (m_act[c]) begin
         if (m_cnt[c] == PKT_LEN) m_act[c] = 1'b0;
         else m_cnt[c]++;
      end
      h_pkt[c][slot] = inp; h_ser[c][slot] = m_ser[c]; h_d[c][slot] = d; h_st[c][slot] = st;
   endfunction

   // R3 R6 R7 R8: every output cycle is compared with the bench model
   task automatic run_stream();
      int it = 0; int idle = 0;
      for (int c = 0; c < NUM_CH; c++) for (int s = 0; s < 8; s++) h_pkt[c][s] = 1'b0;
      while (idle < LAT + 2) begin
         @(negedge clk);
         for (int c = 0; c < NUM_CH; c++) begin
            int s; bit ev;
            s = (it + 4) % 8;
            ev = h_pkt[c][s] && pass_of[c][h_ser[c][s]];
            chk(out_valid[c] == ev, "R8 packet gating", out_valid[c], ev);
            if (ev) begin
               chk(out_data[c*8 +: 8] == h_d[c][s], "R7 forwarded data", out_data[c*8 +: 8], h_d[c][s]);
               chk(out_start[c] == h_st[c][s], "R7 forwarded start", out_start[c], h_st[c][s]);
            end
         end
         for (int c = 0; c < NUM_CH; c++) begin
            if (q[c].size() > 0 && (q[c][0].nogap || $urandom % 4 != 0)) begin
               qb_t b;
               b = q[c].pop_front();
               in_valid[c] = 1'b1; in_start[c] = b.st; in_data[c*8 +: 8] = b.d;
               model_beat(c, it % 8, b.st, b.d);
            end else begin
               in_valid[c] = 1'b0; in_start[c] = 1'b0; in_data[c*8 +: 8] = 8'h00;
               h_pkt[c][it % 8] = 1'b0;
            end
         end
         it++;
         if (q[0].size() == 0 && q[1].size() == 0) idle++;
      end
      in_valid = '0; in_start = '0;
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int c = 0; c < NUM_CH; c++) begin
         m_act[c] = 0; m_cnt[c] = 0; m_ser[c] = 0; m_hdr1[c] = 0;
         for (int a = 0; a < DEPTH; a++) model[c][a] = (a < 4) ? 8'h00 : 8'hFF;
      end
      repeat (5) @(negedge clk);
      chk(out_valid == '0, "R5 reset out_valid", out_valid, 0);
      chk(host_rdata == 8'h00, "R5 reset host_rdata", host_rdata, 0);
      rst_n = 1'b1;
      // during the fill
      rd_chk(1, 12'h050, "R5 fill-time read");
      tbl_write(0, 100, 8'h00, 1'b1);
      hwr(2'd3, 8'h00); // reserved select: no effect
      repeat (1100) @(negedge clk);
      rd_chk(0, 100, "R5 write during fill ignored");
      rd_chk(0, 3, "R4 open byte reads zero");
      rd_chk(0, 4, "R5 first blocked byte");
      rd_chk(1, 1023, "R5 top byte");
      tbl_write(0, 2, 8'hFF, 1'b0);
      rd_chk(0, 2, "R4 write to open byte ignored");
      // default bitmap: only PIDs below 0x20 pass
      gen_pkt(0, 16'h0005, 0); gen_pkt(0, 16'h001F, 0);
      gen_pkt(0, 16'h0020, 0); gen_pkt(0, 16'h1FFF, 0);
      gen_pkt(1, 16'h0000, 0); gen_pkt(1, 16'h0100, 0);
      run_stream();
      // R1 R3: open PID 0x1234 (byte 0x246, bit 4) on stream 1 only
      tbl_write(1, 12'h246, 8'hEF, 1'b0);
      rd_chk(1, 12'h246, "R1 pointer and data round trip");
      rd_chk(0, 12'h246, "R3 other stream untouched");
      gen_pkt(0, 16'h1234, 0); gen_pkt(1, 16'h1234, 0); gen_pkt(1, 16'h1235, 0);
      gen_pkt(1, 16'h1234, 1); gen_pkt(1, 16'h1234, 2); gen_pkt(1, 16'h1234, 3);
      gen_pkt(1, 16'h1234, 0); gen_pkt(0, 16'h0010, 2);
      run_stream();
      // constrained random rounds
      for (int r = 0; r < 4; r++) begin
         wr_list.delete();
         for (int k = 0; k < 30; k++) begin
            int c; int a;
            c = $urandom % 2; a = $urandom % DEPTH;
            tbl_write(c, a, 8'($urandom), 1'b0);
            wr_list.push_back(a);
         end
         for (int k = 0; k < 6; k++) rd_chk($urandom % 2, wr_list[$urandom % wr_list.size()], "R2 readback");
         for (int c = 0; c < NUM_CH; c++)
            for (int p = 0; p < 10; p++) begin
               int pid; int kind; int w;
               if ($urandom % 2) pid = (wr_list[$urandom % wr_list.size()] << 3) | ($urandom % 8);
               else              pid = $urandom % 8192;
               w = $urandom % 10;
               kind = (w < 7) ? 0 : (w - 6);
               gen_pkt(c, pid, kind);
            end
         run_stream();
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule